// File: doc/BRIEF.md
# Channel Configuration SPI Slave

This block is the serial control port of an eight-channel isolated input device. It runs from a system clock that is at least four times faster than SCLK. It synchronizes SCLK, the active-low select and MOSI, then recovers packets of three bytes: a control byte, an address byte and a data byte. The select line frames each byte separately, so it rises between every two bytes.

The block holds a small register map:
- Address 0x0 returns the live state of eight field inputs and is read-only.
- Addresses 0x1 and 0x2 hold the filter mode codes for channels 3..0 and 7..4.
- Addresses 0x3 and 0x4 hold the delay codes for channels 3..0 and 7..4.

Each channel's 2-bit code lies at bits 2n+1:2n of its register. The codes are presented in parallel to a debounce datapath outside this block. A neighbouring chain block decodes the chain ID and supplies a device-select flag.

A byte that does not hold exactly eight clocks breaks framing. The slave then ignores traffic until it sees a rising SCLK while the select line is high, and treats the next framed byte as a control byte.

Top module: `chan_cfg_spi_slave`

## Requirements
- R1: After reset all four read/write registers read 0x00, mode_o and dly_o are zero, and MISO is not driven (miso_oe_o low).
- R2: A complete packet with control bit 6 = 0 and address 0x1..0x4 writes the data byte into that register. The write is committed on the select rise that ends a data byte of exactly eight bits. mode_o[7:0] is register 0x1, mode_o[15:8] is 0x2, dly_o[7:0] is 0x3 and dly_o[15:8] is 0x4, so channel n's field is bits 2n+1:2n.
- R3: A packet with control bit 6 = 1 returns the addressed register MSB first on MISO during the data byte. Address 0x0 returns status_i.
- R4: MISO is driven only during the data byte of a selected read. It is high-impedance during control and address bytes and for the whole of a write.
- R5: A read of any address above 0x4 returns 0x00. A write to address 0x0 or to any address above 0x4 changes no register.
- R6: A write with dev_sel_i low and control bit 7 (broadcast) = 0 changes nothing. With broadcast = 1 the write is applied even when dev_sel_i is low.
- R7: Broadcast is ignored on reads. A read with dev_sel_i low never drives MISO.
- R8: A byte that ends with a count other than eight abandons the packet and leaves the target register unchanged. Later packets are ignored until resynchronization.
- R9: A data byte that receives more than eight SCLK rising edges is discarded.
- R10: A rising SCLK while the select line is high resets the packet state, and the next framed byte is taken as a control byte.
- R11: MISO changes only after falling SCLK edges, so it is steady across each rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCLK |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the master |
| nss_n_i | input | 1 | Active-low byte select |
| mosi_i | input | 1 | Serial data from the master |
| dev_sel_i | input | 1 | This device is addressed by the chain ID |
| status_i | input | 8 | Live field input levels (register 0x0) |
| miso_o | output | 1 | Serial data to the master, high-Z when idle |
| miso_oe_o | output | 1 | MISO drive enable |
| mode_o | output | 16 | Mode codes, 2 bits per channel |
| dly_o | output | 16 | Delay codes, 2 bits per channel |

## Verification
Serial inputs pass two synchronizer flops and one edge-detect register. A select rise is therefore acted on about three clocks after the pin moves, and a register commit is visible one clock after that. A MISO bit appears about four clocks after SCLK falls. The bench holds each SCLK phase for eight clocks and samples MISO on the falling system clock just before it raises SCLK. It samples again four clocks after the rise to confirm the bit is steady. Register outputs are read only eight clocks after the closing select rise, well beyond the commit delay.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
    localparam int BYTE_W        = 8;
    localparam int CH_N          = 8;
    localparam int FLD_W         = 2;
    localparam int CH_PER_REG    = BYTE_W / FLD_W;
    localparam int GRP_REGS      = CH_N / CH_PER_REG;
    localparam int RW_REGS       = 2 * GRP_REGS;
    localparam int ADDR_STATUS   = 0;
    localparam int ADDR_FIRST_RW = 1;
    localparam int CNT_W         = $clog2(BYTE_W + 2);
    localparam int CNT_SAT       = BYTE_W + 1;
    localparam int CTRL_BCAST    = 7;
    localparam int CTRL_RD       = 6;

    typedef enum logic [1:0] {PH_CTRL, PH_ADDR, PH_DATA, PH_LOST} phase_e;

    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    function automatic logic is_rw(input logic [BYTE_W-1:0] a);
        return (int'(a) >= ADDR_FIRST_RW) && (int'(a) < ADDR_FIRST_RW + RW_REGS);
    endfunction
endpackage

// File: rtl/ccs_sync.sv
module ccs_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= RST_VAL;
                else     stg[g] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= RST_VAL;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/ccs_framer.sv
module ccs_framer
    import ccs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_s,
    input  logic              nss_s,
    input  logic              mosi_s,
    input  logic              dev_sel_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic [BYTE_W-1:0] rd_addr_o,
    output wr_req_t           wr_o,
    output logic              miso_bit_o,
    output logic              miso_en_o,
    output phase_e            phase_o,
    output logic [CNT_W-1:0]  bit_cnt_o,
    output logic              sclk_rise_o,
    output logic              nss_rise_o
);
    logic              sclk_d, nss_d;
    logic              sclk_rise, sclk_fall, nss_rise, nss_fall;
    logic [BYTE_W-1:0] shift_q, tx_q, addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              bcast_q, rd_q, sel_q, rd_act_q;
    phase_e            phase_q;
    wr_req_t           wr_q;
    logic              full_byte;

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;
    assign nss_rise  = nss_s & ~nss_d;
    assign nss_fall  = ~nss_s & nss_d;
    assign full_byte = (cnt_q == CNT_W'(BYTE_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d   <= 1'b0;
            nss_d    <= 1'b1;
            shift_q  <= '0;
            tx_q     <= '0;
            addr_q   <= '0;
            cnt_q    <= '0;
            bcast_q  <= 1'b0;
            rd_q     <= 1'b0;
            sel_q    <= 1'b0;
            rd_act_q <= 1'b0;
            phase_q  <= PH_CTRL;
            wr_q     <= '0;
        end else begin
            sclk_d   <= sclk_s;
            nss_d    <= nss_s;
            wr_q.vld <= 1'b0;
            if (sclk_rise && nss_s) begin
                phase_q  <= PH_CTRL;
                cnt_q    <= '0;
                rd_act_q <= 1'b0;
            end else begin
                if (nss_fall) cnt_q <= '0;
                if (sclk_rise && !nss_s) begin
                    shift_q <= {shift_q[BYTE_W-2:0], mosi_s};
                    if (cnt_q < CNT_W'(CNT_SAT)) cnt_q <= cnt_q + 1'b1;
                end
                if (sclk_fall && !nss_s && rd_act_q)
                    tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                if (nss_rise) begin
                    if (!full_byte) begin
                        phase_q  <= PH_LOST;
                        rd_act_q <= 1'b0;
                    end else begin
                        unique case (phase_q)
                            PH_CTRL: begin
                                bcast_q <= shift_q[CTRL_BCAST];
                                rd_q    <= shift_q[CTRL_RD];
                                sel_q   <= dev_sel_i;
                                phase_q <= PH_ADDR;
                            end
                            PH_ADDR: begin
                                addr_q  <= shift_q;
                                phase_q <= PH_DATA;
                                if (rd_q && sel_q) begin
                                    rd_act_q <= 1'b1;
                                    tx_q     <= rd_data_i;
                                end
                            end
                            PH_DATA: begin
                                phase_q  <= PH_CTRL;
                                rd_act_q <= 1'b0;
                                if (!rd_q && (sel_q || bcast_q))
                                    wr_q <= '{vld: 1'b1, addr: addr_q, data: shift_q};
                            end
                            default: phase_q <= PH_LOST;
                        endcase
                    end
                end
            end
        end
    end

    assign rd_addr_o   = shift_q;
    assign wr_o        = wr_q;
    assign miso_bit_o  = tx_q[BYTE_W-1];
    assign miso_en_o   = (phase_q == PH_DATA) && rd_act_q && !nss_s;
    assign phase_o     = phase_q;
    assign bit_cnt_o   = cnt_q;
    assign sclk_rise_o = sclk_rise;
    assign nss_rise_o  = nss_rise;
endmodule

// File: rtl/ccs_regfile.sv
module ccs_regfile
    import ccs_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  wr_req_t                 wr_i,
    input  logic [BYTE_W-1:0]       rd_addr_i,
    input  logic [BYTE_W-1:0]       status_i,
    output logic [BYTE_W-1:0]       rd_data_o,
    output logic [CH_N*FLD_W-1:0]   mode_o,
    output logic [CH_N*FLD_W-1:0]   dly_o
);
    logic [RW_REGS-1:0][BYTE_W-1:0] regs;

    for (genvar g = 0; g < RW_REGS; g++) begin : g_reg
        logic [BYTE_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else if (wr_i.vld && wr_i.addr == BYTE_W'(ADDR_FIRST_RW + g)) q <= wr_i.data;
        end
        assign regs[g] = q;
    end

    for (genvar g = 0; g < GRP_REGS; g++) begin : g_out
        assign mode_o[g*BYTE_W +: BYTE_W] = regs[g];
        assign dly_o[g*BYTE_W +: BYTE_W]  = regs[GRP_REGS + g];
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == BYTE_W'(ADDR_STATUS)) rd_data_o = status_i;
        for (int i = 0; i < RW_REGS; i++)
            if (rd_addr_i == BYTE_W'(ADDR_FIRST_RW + i)) rd_data_o = regs[i];
    end
endmodule

// File: rtl/chan_cfg_spi_slave.sv
module chan_cfg_spi_slave
    import ccs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sclk_i,
    input  logic                  nss_n_i,
    input  logic                  mosi_i,
    input  logic                  dev_sel_i,
    input  logic [CH_N-1:0]       status_i,
    output logic                  miso_o,
    output logic                  miso_oe_o,
    output logic [CH_N*FLD_W-1:0] mode_o,
    output logic [CH_N*FLD_W-1:0] dly_o
);
    logic              sclk_s, nss_s, mosi_s;
    logic              sclk_rise, nss_rise, miso_en, miso_bit;
    logic [BYTE_W-1:0] rd_addr, rd_data;
    logic [CNT_W-1:0]  bit_cnt;
    phase_e            phase;
    wr_req_t           wr;

    ccs_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b010)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({sclk_i, nss_n_i, mosi_i}),
        .q_o ({sclk_s, nss_s, mosi_s})
    );

    ccs_framer u_frm (
        .clk         (clk),
        .rst         (rst),
        .sclk_s      (sclk_s),
        .nss_s       (nss_s),
        .mosi_s      (mosi_s),
        .dev_sel_i   (dev_sel_i),
        .rd_data_i   (rd_data),
        .rd_addr_o   (rd_addr),
        .wr_o        (wr),
        .miso_bit_o  (miso_bit),
        .miso_en_o   (miso_en),
        .phase_o     (phase),
        .bit_cnt_o   (bit_cnt),
        .sclk_rise_o (sclk_rise),
        .nss_rise_o  (nss_rise)
    );

    ccs_regfile u_rf (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (wr),
        .rd_addr_i (rd_addr),
        .status_i  (status_i),
        .rd_data_o (rd_data),
        .mode_o    (mode_o),
        .dly_o     (dly_o)
    );

    assign miso_oe_o = miso_en;
    assign miso_o    = miso_en ? miso_bit : 1'bz;
endmodule

// File: rtl/ccs_checker.sv
module ccs_checker
    import ccs_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  sclk_rise,
    input logic                  nss_s,
    input logic                  nss_rise,
    input logic                  miso_en,
    input logic                  miso_bit,
    input phase_e                phase,
    input logic [CNT_W-1:0]      bit_cnt,
    input wr_req_t               wr,
    input logic [CH_N*FLD_W-1:0] mode_o,
    input logic [CH_N*FLD_W-1:0] dly_o
);
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !miso_en);

    a_r2_commit_after_nss: assert property (@(posedge clk) disable iff (rst)
        wr.vld |-> $past(nss_rise));

    a_r2_change_needs_write: assert property (@(posedge clk) disable iff (rst)
        !($stable(mode_o) && $stable(dly_o)) |-> $past(wr.vld));

    a_r5_unmapped_dropped: assert property (@(posedge clk) disable iff (rst)
        (wr.vld && !is_rw(wr.addr)) |=> ($stable(mode_o) && $stable(dly_o)));

    a_r8_lost_sticky: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOST && !(sclk_rise && nss_s)) |=> phase == PH_LOST);

    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= CNT_W'(CNT_SAT));

    a_r10_resync: assert property (@(posedge clk) disable iff (rst)
        (sclk_rise && nss_s) |=> phase == PH_CTRL);

    a_r11_miso_steady: assert property (@(posedge clk) disable iff (rst)
        (sclk_rise && !nss_s && miso_en) |-> $stable(miso_bit));
endmodule

bind chan_cfg_spi_slave ccs_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .sclk_rise (sclk_rise),
    .nss_s     (nss_s),
    .nss_rise  (nss_rise),
    .miso_en   (miso_en),
    .miso_bit  (miso_bit),
    .phase     (phase),
    .bit_cnt   (bit_cnt),
    .wr        (wr),
    .mode_o    (mode_o),
    .dly_o     (dly_o)
);

// File: tb/chan_cfg_spi_slave_tb_top.sv
module chan_cfg_spi_slave_tb_top;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst, sclk, nss_n, mosi, dev_sel;
    logic [7:0]  status;
    logic        miso, miso_oe;
    logic [15:0] mode, dly;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    chan_cfg_spi_slave dut_i (
        .clk       (clk),
        .rst       (rst),
        .sclk_i    (sclk),
        .nss_n_i   (nss_n),
        .mosi_i    (mosi),
        .dev_sel_i (dev_sel),
        .status_i  (status),
        .miso_o    (miso),
        .miso_oe_o (miso_oe),
        .mode_o    (mode),
        .dly_o     (dly)
    );

    typedef struct {
        string       req;
        logic [15:0] v;
    } item_t;

    item_t exp_q[$];
    item_t act_q[$];
    int    n_chk = 0;
    int    n_bad = 0;

    task automatic push_exp(input string r, input logic [15:0] e);
        exp_q.push_back('{req: r, v: e});
    endtask

    task automatic push_act(input string r, input logic [15:0] a);
        act_q.push_back('{req: r, v: a});
    endtask

    always @(negedge clk) begin
        item_t e, a;
        if (exp_q.size() > 0 && act_q.size() > 0) begin
            e = exp_q.pop_front();
            a = act_q.pop_front();
            n_chk++;
            if (a.v !== e.v) begin
                n_bad++;
                $display("FAIL %s actual=%h expected=%h", e.req, a.v, e.v);
            end
        end
    end

    task automatic clk_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    // rx: bits seen before each rising SCLK; quiet: enable low at every sample;
    // steady: MISO unchanged across each rising SCLK
    task automatic spi_byte(input logic [7:0] b, input int nbits,
                            output logic [7:0] rx, output logic quiet, output logic steady);
        logic m0;
        rx = '0; quiet = 1'b1; steady = 1'b1;
        nss_n = 1'b0;
        clk_wait(4);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 8) ? b[7-i] : 1'b0;
            clk_wait(HALF);
            m0 = miso;
            if (miso_oe !== 1'b0) quiet = 1'b0;
            rx = {rx[6:0], (miso_oe === 1'b1) && (m0 === 1'b1)};
            sclk = 1'b1;
            clk_wait(4);
            if (miso_oe === 1'b1 && miso !== m0) steady = 1'b0;
            clk_wait(HALF - 4);
            sclk = 1'b0;
        end
        clk_wait(HALF);
        nss_n = 1'b1;
        clk_wait(8);
    endtask

    task automatic xfer(input logic [7:0] c, input logic [7:0] a, input logic [7:0] d,
                        input int last_bits, output logic [7:0] rx,
                        output logic hdr_quiet, output logic dat_quiet, output logic steady);
        logic [7:0] junk;
        logic q0, q1, s0;
        spi_byte(c, 8, junk, q0, s0);
        spi_byte(a, 8, junk, q1, s0);
        hdr_quiet = q0 & q1;
        spi_byte(d, last_bits, rx, dat_quiet, steady);
    endtask

    task automatic resync();
        nss_n = 1'b1;
        clk_wait(4);
        sclk = 1'b1;
        clk_wait(6);
        sclk = 1'b0;
        clk_wait(6);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx;
        logic hq, dq, st;
        rst = 1'b1; sclk = 1'b0; nss_n = 1'b1; mosi = 1'b0;
        dev_sel = 1'b1; status = 8'h6B;
        clk_wait(5);
        rst = 1'b0;
        clk_wait(5);

        // R1 reset state
        push_exp("R1 mode", 16'h0000); push_act("R1 mode", mode);
        push_exp("R1 dly", 16'h0000);  push_act("R1 dly", dly);
        push_exp("R1 miso_oe", 16'h0); push_act("R1 miso_oe", {15'b0, miso_oe});

        // R2 writes; R4 write data byte leaves MISO undriven
        xfer(8'h00, 8'h01, 8'hA5, 8, rx, hq, dq, st);
        push_exp("R4 write quiet", 16'h1); push_act("R4 write quiet", {15'b0, dq & hq});
        xfer(8'h00, 8'h02, 8'h96, 8, rx, hq, dq, st);
        xfer(8'h00, 8'h03, 8'h5A, 8, rx, hq, dq, st);
        xfer(8'h00, 8'h04, 8'h3C, 8, rx, hq, dq, st);
        push_exp("R2 mode", 16'h96A5); push_act("R2 mode", mode);
        push_exp("R2 dly", 16'h3C5A);  push_act("R2 dly", dly);
        push_exp("R2 ch5 mode field", 16'h1); push_act("R2 ch5 mode field", {14'b0, mode[11:10]});

        // R3 reads, R4 header bytes quiet, R11 steady MISO
        xfer(8'h40, 8'h01, 8'h00, 8, rx, hq, dq, st);
        push_exp("R3 read 0x1", 16'h00A5); push_act("R3 read 0x1", {8'b0, rx});
        push_exp("R4 read header quiet", 16'h1); push_act("R4 read header quiet", {15'b0, hq});
        push_exp("R11 steady", 16'h1); push_act("R11 steady", {15'b0, st});
        xfer(8'h40, 8'h04, 8'h00, 8, rx, hq, dq, st);
        push_exp("R3 read 0x4", 16'h003C); push_act("R3 read 0x4", {8'b0, rx});
        xfer(8'h40, 8'h00, 8'h00, 8, rx, hq, dq, st);
        push_exp("R3 read status", 16'h006B); push_act("R3 read status", {8'b0, rx});
        push_exp("R11 steady status", 16'h1); push_act("R11 steady status", {15'b0, st});

        // R5 unmapped accesses
        xfer(8'h40, 8'h05, 8'h00, 8, rx, hq, dq, st);
        push_exp("R5 read 0x05", 16'h0000); push_act("R5 read 0x05", {8'b0, rx});
        xfer(8'h40, 8'hFF, 8'h00, 8, rx, hq, dq, st);
        push_exp("R5 read 0xFF", 16'h0000); push_act("R5 read 0xFF", {8'b0, rx});
        xfer(8'h00, 8'h05, 8'hFF, 8, rx, hq, dq, st);
        xfer(8'h00, 8'h00, 8'hFF, 8, rx, hq, dq, st);
        push_exp("R5 mode kept", 16'h96A5); push_act("R5 mode kept", mode);
        push_exp("R5 dly kept", 16'h3C5A);  push_act("R5 dly kept", dly);

        // R6 select and broadcast on writes
        dev_sel = 1'b0;
        xfer(8'h00, 8'h01, 8'h11, 8, rx, hq, dq, st);
        push_exp("R6 unselected write", 16'h96A5); push_act("R6 unselected write", mode);
        xfer(8'h80, 8'h01, 8'h11, 8, rx, hq, dq, st);
        push_exp("R6 broadcast write", 16'h9611); push_act("R6 broadcast write", mode);

        // R7 broadcast ignored on reads
        xfer(8'hC0, 8'h01, 8'h00, 8, rx, hq, dq, st);
        push_exp("R7 unselected read quiet", 16'h1); push_act("R7 unselected read quiet", {15'b0, dq});
        dev_sel = 1'b1;

        // R8 abandoned write, then traffic ignored while out of sync
        xfer(8'h00, 8'h02, 8'h00, 5, rx, hq, dq, st);
        push_exp("R8 abandoned write", 16'h9611); push_act("R8 abandoned write", mode);
        xfer(8'h00, 8'h02, 8'h77, 8, rx, hq, dq, st);
        push_exp("R8 ignored while lost", 16'h9611); push_act("R8 ignored while lost", mode);

        // R10 resync restores framing
        resync();
        xfer(8'h00, 8'h02, 8'h77, 8, rx, hq, dq, st);
        push_exp("R10 write after resync", 16'h7711); push_act("R10 write after resync", mode);

        // R9 over-long data byte
        xfer(8'h00, 8'h03, 8'hEE, 9, rx, hq, dq, st);
        push_exp("R9 long byte dropped", 16'h3C5A); push_act("R9 long byte dropped", dly);
        resync();
        xfer(8'h40, 8'h03, 8'h00, 8, rx, hq, dq, st);
        push_exp("R10 read after resync", 16'h005A); push_act("R10 read after resync", {8'b0, rx});

        while (exp_q.size() > 0 || act_q.size() > 0) clk_wait(1);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule